// File: doc/BRIEF.md
# Two-Phase Flit Link Endpoint

This block is one port of a mesh router's link layer. It moves fixed-format flits across a point-to-point channel using a two-phase toggle handshake. The sender side takes a flit from the local fabric, places it on the outgoing data lines and inverts its request level. The receiver side watches the incoming request level. When that level differs from its own acknowledge level, it stores the flit in a one-entry buffer and inverts the acknowledge. A transfer is finished when the two levels agree again, so a flit occupies two clock cycles on the wire.

Every flit carries a two-bit kind tag next to a payload of configurable width. The tag marks the flit as the header that opens a route, a body flit, the tail that closes it, or a packet made of one flit only. Flits pass through without change. On the receive side, the block decodes the tag into start-of-packet and end-of-packet markers for the wormhole switching logic behind it. When that logic stops draining the buffer, the acknowledge is held back, and the remote sender stalls.

A router instantiates one of these per neighbour direction and one for its local element. The outgoing link of one endpoint is wired to the incoming link of the neighbour's endpoint.

Top module: `abl_flit_link`

## Requirements
- R1: During and after reset, lo_req and li_ack are 0 and rx_valid is 0. With lo_ack at 0, tx_ready is 1, so the link starts matched and idle.
- R2: tx_ready is high exactly when lo_req equals lo_ack. A flit is accepted on a clock edge where tx_valid and tx_ready are both high.
- R3: One cycle after a flit is accepted, lo_kind and lo_data show that flit and lo_req has inverted.
- R4: While lo_req differs from lo_ack, lo_req, lo_kind and lo_data hold steady and tx_valid has no effect.
- R5: When li_req differs from li_ack and the receive buffer is empty, the incoming flit is stored and li_ack inverts on the next edge. In all other cases li_ack keeps its level.
- R6: While the buffer is full, li_ack does not change, whatever li_req does. A flit is drained on an edge where rx_valid and rx_ready are both high. A pending incoming flit is then stored, and li_ack inverted, on the following edge.
- R7: rx_kind and rx_data present the stored flit exactly as it arrived. Flits leave in arrival order.
- R8: The kind code is 2'b01 for header, 2'b00 for body, 2'b10 for tail and 2'b11 for single-flit packet. rx_sop is rx_valid AND kind bit 0. rx_eop is rx_valid AND kind bit 1.
- R9: With the outgoing link looped back to the incoming link, the receiver always ready and tx_valid held high, the sender accepts a new flit every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A flit is offered for sending |
| tx_kind | input | 2 | Kind tag of the offered flit |
| tx_data | input | PAYLOAD_W | Payload of the offered flit |
| tx_ready | output | 1 | Sender can accept a flit |
| lo_kind | output | 2 | Outgoing link kind tag |
| lo_data | output | PAYLOAD_W | Outgoing link payload |
| lo_req | output | 1 | Outgoing request level |
| lo_ack | input | 1 | Acknowledge level returned by the neighbour |
| li_kind | input | 2 | Incoming link kind tag |
| li_data | input | PAYLOAD_W | Incoming link payload |
| li_req | input | 1 | Incoming request level |
| li_ack | output | 1 | Acknowledge level returned to the neighbour |
| rx_valid | output | 1 | Receive buffer holds a flit |
| rx_ready | input | 1 | Consumer takes the buffered flit |
| rx_kind | output | 2 | Kind tag of the buffered flit |
| rx_data | output | PAYLOAD_W | Payload of the buffered flit |
| rx_sop | output | 1 | Buffered flit opens a packet |
| rx_eop | output | 1 | Buffered flit closes a packet |

## Verification
An accepted flit shows up on the outgoing link, with the request inverted, one edge after acceptance. The receiver stores it and inverts the acknowledge one edge after that. The sender's ready returns in the cycle after the acknowledge, which gives the two-cycle spacing. A flit held in the buffer appears on the receive outputs in the cycle after it is stored. After a drain, a waiting flit is taken one edge later. The bench runs a behavioural model that takes these same edges. It samples every output at the falling edge between them, so each result is compared in the exact cycle it is due.

// File: rtl/abl_pkg.sv
package abl_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_BODY = 2'b00,
    KIND_HEAD = 2'b01,
    KIND_TAIL = 2'b10,
    KIND_SOLO = 2'b11
  } flit_kind_e;

  // bit positions of the boundary markers inside the kind code
  localparam int OPEN_BIT  = 0;
  localparam int CLOSE_BIT = 1;
endpackage

// File: rtl/abl_tx.sv
module abl_tx
  import abl_pkg::*;
#(
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_valid,
  input  logic [KIND_W-1:0]    up_kind,
  input  logic [PAYLOAD_W-1:0] up_data,
  output logic                 up_ready,
  output logic                 req_o,
  input  logic                 ack_i,
  output logic [KIND_W-1:0]    kind_o,
  output logic [PAYLOAD_W-1:0] data_o
);
  logic                 req_q, req_d;
  logic [KIND_W-1:0]    kind_q, kind_d;
  logic [PAYLOAD_W-1:0] data_q, data_d;
  logic                 levels_match;
  logic                 launch;

  always_comb begin
    levels_match = (req_q == ack_i);
    launch       = up_valid & levels_match;
    req_d        = req_q ^ launch;
    kind_d       = kind_q;
    data_d       = data_q;
    if (launch) begin
      kind_d = up_kind;
      data_d = up_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      kind_q <= '0;
      data_q <= '0;
    end else begin
      req_q <= req_d;
      if (launch) begin
        kind_q <= kind_d;
        data_q <= data_d;
      end
    end
  end

  assign up_ready = levels_match;
  assign req_o    = req_q;
  assign kind_o   = kind_q;
  assign data_o   = data_q;
endmodule

// File: rtl/abl_rx.sv
module abl_rx
  import abl_pkg::*;
#(
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [KIND_W-1:0]    kind_i,
  input  logic [PAYLOAD_W-1:0] data_i,
  output logic                 ack_o,
  output logic                 dn_valid,
  input  logic                 dn_ready,
  output logic [KIND_W-1:0]    dn_kind,
  output logic [PAYLOAD_W-1:0] dn_data
);
  logic                 ack_q, ack_d;
  logic                 full_q, full_d;
  logic [KIND_W-1:0]    kind_q;
  logic [PAYLOAD_W-1:0] data_q;
  logic                 pending;
  logic                 take;
  logic                 drain;

  always_comb begin
    pending = req_i ^ ack_q;
    take    = pending & ~full_q;
    drain   = full_q & dn_ready;
    full_d  = take | (full_q & ~drain);
    ack_d   = ack_q ^ take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      full_q <= 1'b0;
      kind_q <= '0;
      data_q <= '0;
    end else begin
      ack_q  <= ack_d;
      full_q <= full_d;
      if (take) begin
        kind_q <= kind_i;
        data_q <= data_i;
      end
    end
  end

  assign ack_o    = ack_q;
  assign dn_valid = full_q;
  assign dn_kind  = kind_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/abl_bound.sv
module abl_bound
  import abl_pkg::*;
(
  input  logic              valid_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic              sop_o,
  output logic              eop_o
);
  assign sop_o = valid_i & kind_i[OPEN_BIT];
  assign eop_o = valid_i & kind_i[CLOSE_BIT];
endmodule

// File: rtl/abl_flit_link.sv
module abl_flit_link
  import abl_pkg::*;
#(
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  input  logic [1:0]           tx_kind,
  input  logic [PAYLOAD_W-1:0] tx_data,
  output logic                 tx_ready,
  output logic [1:0]           lo_kind,
  output logic [PAYLOAD_W-1:0] lo_data,
  output logic                 lo_req,
  input  logic                 lo_ack,
  input  logic [1:0]           li_kind,
  input  logic [PAYLOAD_W-1:0] li_data,
  input  logic                 li_req,
  output logic                 li_ack,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [1:0]           rx_kind,
  output logic [PAYLOAD_W-1:0] rx_data,
  output logic                 rx_sop,
  output logic                 rx_eop
);
  abl_tx #(.PAYLOAD_W(PAYLOAD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (tx_valid),
    .up_kind  (tx_kind),
    .up_data  (tx_data),
    .up_ready (tx_ready),
    .req_o    (lo_req),
    .ack_i    (lo_ack),
    .kind_o   (lo_kind),
    .data_o   (lo_data)
  );

  abl_rx #(.PAYLOAD_W(PAYLOAD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (li_req),
    .kind_i   (li_kind),
    .data_i   (li_data),
    .ack_o    (li_ack),
    .dn_valid (rx_valid),
    .dn_ready (rx_ready),
    .dn_kind  (rx_kind),
    .dn_data  (rx_data)
  );

  abl_bound u_bound (
    .valid_i (rx_valid),
    .kind_i  (rx_kind),
    .sop_o   (rx_sop),
    .eop_o   (rx_eop)
  );
endmodule

// File: rtl/abl_flit_link_chk.sv
module abl_flit_link_chk #(
  parameter int PAYLOAD_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic                 lo_req,
  input logic                 lo_ack,
  input logic [1:0]           lo_kind,
  input logic [PAYLOAD_W-1:0] lo_data,
  input logic                 li_req,
  input logic                 li_ack,
  input logic [1:0]           li_kind,
  input logic [PAYLOAD_W-1:0] li_data,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic [1:0]           rx_kind,
  input logic [PAYLOAD_W-1:0] rx_data
);
  // R3
  req_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (lo_req != $past(lo_req)));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req != lo_ack) |=> ($stable(lo_req) && $stable(lo_kind) && $stable(lo_data)));

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (li_req == li_ack) |=> $stable(li_ack));

  // R6
  ack_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(li_ack));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (li_req != li_ack && !rx_valid) |=>
      (rx_valid && rx_kind == $past(li_kind) && rx_data == $past(li_data)));
endmodule

bind abl_flit_link abl_flit_link_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .lo_req   (lo_req),
  .lo_ack   (lo_ack),
  .lo_kind  (lo_kind),
  .lo_data  (lo_data),
  .li_req   (li_req),
  .li_ack   (li_ack),
  .li_kind  (li_kind),
  .li_data  (li_data),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_kind  (rx_kind),
  .rx_data  (rx_data)
);

// File: tb/abl_flit_link_tb.sv
module abl_flit_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_valid = 1'b0;
  logic [1:0]   tx_kind = '0;
  logic [W-1:0] tx_data = '0;
  logic         tx_ready;
  logic [1:0]   lo_kind;
  logic [W-1:0] lo_data;
  logic         lo_req;
  logic         li_ack;
  logic         rx_valid;
  logic         rx_ready = 1'b1;
  logic [1:0]   rx_kind;
  logic [W-1:0] rx_data;
  logic         rx_sop;
  logic         rx_eop;

  always #(CLK_PERIOD/2) clk = ~clk;

  // outgoing link looped back into the incoming link
  abl_flit_link #(.PAYLOAD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_data(tx_data), .tx_ready(tx_ready),
    .lo_kind(lo_kind), .lo_data(lo_data), .lo_req(lo_req), .lo_ack(li_ack),
    .li_kind(lo_kind), .li_data(lo_data), .li_req(lo_req), .li_ack(li_ack),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_kind(rx_kind), .rx_data(rx_data),
    .rx_sop(rx_sop), .rx_eop(rx_eop)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // behavioural reference model
  bit               m_req, m_ack;
  logic [1:0]       m_lkind;
  logic [W-1:0]     m_ldata;
  logic [W+1:0]     m_buf[$];
  logic [W+1:0]     stim_q[$];
  int               cyc;
  int               last_fire;
  bit               spacing_on;
  bit               fired;
  bit               run_cmp;
  int               rdy_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_ack = 0; m_lkind = '0; m_ldata = '0;
      m_buf.delete(); cyc = 0; fired = 0; last_fire = -1;
    end else begin
      bit f, c, d;
      cyc++;
      f = tx_valid && (m_req == m_ack);
      c = (m_req != m_ack) && (m_buf.size() == 0);
      d = (m_buf.size() > 0) && rx_ready;
      if (d) void'(m_buf.pop_front());
      if (c) begin
        m_buf.push_back({m_lkind, m_ldata});
        m_ack = ~m_ack;
      end
      if (f) begin
        m_lkind = tx_kind;
        m_ldata = tx_data;
        m_req   = ~m_req;
        // R9 spacing between accepted flits
        if (spacing_on && last_fire >= 0)
          chk(cyc - last_fire == 2, "R9", "accept spacing", cyc - last_fire, 2);
        last_fire = cyc;
      end
      fired = f;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(lo_req == m_req, "R3", "lo_req", lo_req, m_req);
      chk(lo_kind == m_lkind && lo_data == m_ldata, "R3", "link flit",
          {lo_kind, lo_data}, {m_lkind, m_ldata});
      chk(li_ack == m_ack, "R5", "li_ack", li_ack, m_ack);
      chk(tx_ready == (m_req == m_ack), "R2", "tx_ready", tx_ready, m_req == m_ack);
      chk(rx_valid == (m_buf.size() > 0), "R6", "rx_valid", rx_valid, m_buf.size() > 0);
      if (m_buf.size() > 0) begin
        chk({rx_kind, rx_data} == m_buf[0], "R7", "rx flit", {rx_kind, rx_data}, m_buf[0]);
        chk(rx_sop == m_buf[0][W], "R8", "rx_sop", rx_sop, m_buf[0][W]);
        chk(rx_eop == m_buf[0][W+1], "R8", "rx_eop", rx_eop, m_buf[0][W+1]);
      end else begin
        chk(!rx_sop && !rx_eop, "R8", "markers while empty", {rx_sop, rx_eop}, 0);
      end
    end
    // stimulus driver
    if (fired) begin
      void'(stim_q.pop_front());
      fired = 0;
    end
    tx_valid = (stim_q.size() > 0);
    if (stim_q.size() > 0) begin
      tx_kind = stim_q[0][W+1:W];
      tx_data = stim_q[0][W-1:0];
    end else begin
      tx_kind = 2'($urandom);
      tx_data = W'($urandom);
    end
    case (rdy_mode)
      0: rx_ready = 1'b1;
      1: rx_ready = 1'b0;
      default: rx_ready = 1'($urandom);
    endcase
  end

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (stim_q.size() == 0 && m_buf.size() == 0 && m_req == m_ack && !fired) break;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic         hold_ack, hold_req;
    logic [W-1:0] hold_data;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lo_req == 0, "R1", "lo_req in reset", lo_req, 0);
    chk(li_ack == 0, "R1", "li_ack in reset", li_ack, 0);
    chk(rx_valid == 0, "R1", "rx_valid in reset", rx_valid, 0);
    chk(tx_ready == 1, "R1", "tx_ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lo_req == 0 && li_ack == 0 && rx_valid == 0 && tx_ready == 1, "R1",
        "state after release", {lo_req, li_ack, rx_valid, tx_ready}, 4'b0001);
    run_cmp = 1;

    // packet of head/body/body/tail then a single-flit packet, consumer always ready
    rdy_mode = 0;
    spacing_on = 1;
    last_fire = -1;
    stim_q.push_back({2'b01, 16'h1111});
    stim_q.push_back({2'b00, 16'h2222});
    stim_q.push_back({2'b00, 16'h3333});
    stim_q.push_back({2'b10, 16'h4444});
    stim_q.push_back({2'b11, 16'h5555});
    wait_idle();
    spacing_on = 0;

    // consumer stalls: buffer fills, second flit blocked on the wire
    rdy_mode = 1;
    stim_q.push_back({2'b01, 16'hA0A0});
    stim_q.push_back({2'b10, 16'hB1B1});
    stim_q.push_back({2'b11, 16'hC2C2});
    repeat (12) @(negedge clk);
    hold_ack = li_ack; hold_req = lo_req; hold_data = lo_data;
    repeat (8) @(negedge clk);
    // R6 acknowledge held while the buffer stays full
    chk(li_ack == hold_ack, "R6", "li_ack during stall", li_ack, hold_ack);
    // R4 sender frozen while levels differ, tx_valid still high
    chk(lo_req == hold_req && lo_data == hold_data && tx_ready == 0, "R4",
        "link hold", {lo_req, lo_data}, {hold_req, hold_data});
    rdy_mode = 0;
    wait_idle();

    // random traffic with an erratic consumer
    rdy_mode = 2;
    for (int i = 0; i < 150; i++)
      stim_q.push_back({2'($urandom), W'($urandom)});
    wait_idle();
    chk(stim_q.size() == 0 && m_buf.size() == 0, "R7", "all flits delivered",
        stim_q.size() + m_buf.size(), 0);

    done = 1;
    finish_run();
  end
endmodule